// File: doc/BRIEF.md
# Ownership-Handoff Shared Mailbox

A 256-bit register aperture that two functions share: a requester and a server. It appears as eight 32-bit words on each of two register ports, one port per function. Only one side may change the contents at a time. A bit held in the top word records which side that is. The requester fills the words and then writes the top header word. That write passes ownership to the server and sends the server a one-cycle notification. The server reads the request and writes its response into the header word. That write hands ownership back to the requester. The requester then polls bit 31 of the header word to see when the response is ready.

The header word carries the message type in bits [2:0] and the version in bits [5:3]. Bit 7 gives the direction (0 request, 1 response). Bits [15:8] hold the status (0 success, nonzero failure) and bit 24 is a reset-function flag. Bit 31 is always the live ownership bit, whatever value was written there. While the requesting function is held in reset, every read on the requester port returns all ones, so its poll loop still ends. Reads on both ports are combinational. Writes take effect at the clock edge.

Top module: `handoff_mailbox`

## Requirements
- R1: After power-on reset (rst_n low), all eight words read as zero on both ports, the requester owns the mailbox (srv_owns = 0) and srv_notify is low.
- R2: While the requester owns the mailbox, a requester write to any word 0..6 stores the data, which reads back on both ports from the next cycle.
- R3: While the requester owns the mailbox, a requester write to word 7 stores bits [30:0] and gives ownership to the server. Word 7 then reads with bit 31 = 1 regardless of the written bit 31, and srv_owns = 1.
- R4: srv_notify is high for exactly one cycle, in the cycle after the write that gave ownership to the server, and at no other time.
- R5: While the server owns the mailbox, requester writes to any word (including word 7) change no word and do not raise srv_notify.
- R6: While the requester owns the mailbox, server writes to any word change no word.
- R7: While the server owns the mailbox, a server write to words 0..6 stores the data. A server write to word 7 stores bits [30:0] (direction bit 7, status bits [15:8]) and returns ownership to the requester, so bit 31 of word 7 reads 0.
- R8: While fn_in_reset is high, req_rdata is 0xFFFFFFFF for every word. srv_rdata and the stored contents are unaffected, and the real contents appear again once fn_in_reset falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| fn_in_reset | input | 1 | Requesting function is held in reset |
| req_addr | input | 3 | Requester word index (byte offset / 4) |
| req_wr | input | 1 | Requester write strobe |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data |
| srv_addr | input | 3 | Server word index |
| srv_wr | input | 1 | Server write strobe |
| srv_wdata | input | 32 | Server write data |
| srv_rdata | output | 32 | Server read data |
| srv_owns | output | 1 | Server currently owns the mailbox |
| srv_notify | output | 1 | One-cycle pulse when ownership passes to the server |

## Verification
The assertions rely on the two ports obeying the ownership protocol only to the extent that write strobes are clean, known values at each clock edge. Ownership may change only through a write to word 7 by the current owner. The bench drives every strobe, address and data value on the falling edge, so each is stable at the rising edge. It also deliberately issues writes from the non-owning side, to show that those writes are dropped rather than avoided.

// File: rtl/handoff_mailbox.sv
module handoff_mailbox #(
  parameter int WORDS = 8,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fn_in_reset,
  input  logic [$clog2(WORDS)-1:0] req_addr,
  input  logic                     req_wr,
  input  logic [DW-1:0]            req_wdata,
  output logic [DW-1:0]            req_rdata,
  input  logic [$clog2(WORDS)-1:0] srv_addr,
  input  logic                     srv_wr,
  input  logic [DW-1:0]            srv_wdata,
  output logic [DW-1:0]            srv_rdata,
  output logic                     srv_owns,
  output logic                     srv_notify
);
  localparam int AW = $clog2(WORDS);
  localparam logic [AW-1:0] HDR = AW'(WORDS - 1);

  logic [DW-1:0] mem  [WORDS];
  logic [DW-1:0] view [WORDS];
  logic owner, notify_q;

  wire req_ok = req_wr && !owner;
  wire srv_ok = srv_wr && owner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      owner    <= 1'b0;
      notify_q <= 1'b0;
    end else begin
      if (req_ok) mem[req_addr] <= req_wdata;
      else if (srv_ok) mem[srv_addr] <= srv_wdata;
      if (req_ok && req_addr == HDR) owner <= 1'b1;
      else if (srv_ok && srv_addr == HDR) owner <= 1'b0;
      notify_q <= req_ok && (req_addr == HDR);
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_view
    if (g == WORDS - 1) begin : g_hdr
      assign view[g] = {owner, mem[g][DW-2:0]};
    end else begin : g_data
      assign view[g] = mem[g];
    end
  end

  assign req_rdata  = fn_in_reset ? '1 : view[req_addr];
  assign srv_rdata  = view[srv_addr];
  assign srv_owns   = owner;
  assign srv_notify = notify_q;
endmodule

module handoff_mailbox_chk #(
  parameter int WORDS = 8,
  parameter int DW    = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     fn_in_reset,
  input logic [$clog2(WORDS)-1:0] req_addr,
  input logic                     req_wr,
  input logic [DW-1:0]            req_rdata,
  input logic [$clog2(WORDS)-1:0] srv_addr,
  input logic                     srv_wr,
  input logic [DW-1:0]            srv_rdata,
  input logic                     srv_owns,
  input logic                     srv_notify
);
  localparam int AW = $clog2(WORDS);
  localparam logic [AW-1:0] HDR = AW'(WORDS - 1);

  // R4
  notify_on_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srv_notify |-> srv_owns && !$past(srv_owns));
  // R4
  notify_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srv_notify |=> !srv_notify);
  // R5
  srv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srv_owns && !(srv_wr && srv_addr == HDR) |=> srv_owns);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !srv_owns && !(req_wr && req_addr == HDR) |=> !srv_owns);
  // R3
  owner_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srv_addr == HDR |-> srv_rdata[DW-1] == srv_owns);
  // R8
  reset_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fn_in_reset |-> req_rdata == '1);
endmodule

bind handoff_mailbox handoff_mailbox_chk #(.WORDS(WORDS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fn_in_reset(fn_in_reset),
  .req_addr(req_addr), .req_wr(req_wr), .req_rdata(req_rdata),
  .srv_addr(srv_addr), .srv_wr(srv_wr), .srv_rdata(srv_rdata),
  .srv_owns(srv_owns), .srv_notify(srv_notify)
);

// File: tb/handoff_mailbox_bench.sv
`timescale 1ns/1ps
module handoff_mailbox_bench;
  logic clk = 0, rst_n = 0, fn_in_reset = 0;
  logic [2:0] req_addr = 0, srv_addr = 0;
  logic req_wr = 0, srv_wr = 0;
  logic [31:0] req_wdata = 0, srv_wdata = 0;
  logic [31:0] req_rdata, srv_rdata;
  logic srv_owns, srv_notify;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  handoff_mailbox u_handoff_mailbox (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic read_both(input logic [2:0] a, output logic [31:0] r, output logic [31:0] s);
    req_addr = a; srv_addr = a; #0.5;
    r = req_rdata; s = srv_rdata;
  endtask

  task automatic req_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req_addr = a; req_wdata = d; req_wr = 1;
    @(negedge clk); req_wr = 0;
  endtask

  task automatic srv_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); srv_addr = a; srv_wdata = d; srv_wr = 1;
    @(negedge clk); srv_wr = 0;
  endtask

  task automatic t_reset();
    logic [31:0] r, s;
    for (int i = 0; i < 8; i++) begin
      read_both(3'(i), r, s);
      check("R1 req word", r, 0);
      check("R1 srv word", s, 0);
    end
    check("R1 owner", {31'b0, srv_owns}, 0);
    check("R1 notify", {31'b0, srv_notify}, 0);
  endtask

  task automatic t_req_fill();
    logic [31:0] r, s;
    for (int i = 0; i < 7; i++) req_write(3'(i), 32'hA5000000 | 32'(i * 16'h1111));
    for (int i = 0; i < 7; i++) begin
      read_both(3'(i), r, s);
      check("R2 req readback", r, 32'hA5000000 | 32'(i * 16'h1111));
      check("R2 srv readback", s, 32'hA5000000 | 32'(i * 16'h1111));
    end
  endtask

  task automatic t_srv_ignored();
    logic [31:0] r, s;
    srv_write(3'd2, 32'hDEADBEEF);
    srv_write(3'd7, 32'h00000081);
    read_both(3'd2, r, s);
    check("R6 word2 kept", s, 32'hA5002222);
    read_both(3'd7, r, s);
    check("R6 header kept", s, 0);
    check("R6 owner", {31'b0, srv_owns}, 0);
  endtask

  task automatic t_handoff();
    logic [31:0] r, s;
    @(negedge clk); req_addr = 3'd7; req_wdata = 32'h01000001; req_wr = 1;
    @(posedge clk); #1;
    check("R4 notify high", {31'b0, srv_notify}, 1);
    check("R3 owner set", {31'b0, srv_owns}, 1);
    @(negedge clk); req_wr = 0;
    @(posedge clk); #1;
    check("R4 notify one cycle", {31'b0, srv_notify}, 0);
    read_both(3'd7, r, s);
    check("R3 header bit31", s, 32'h81000001);
    check("R3 header req port", r, 32'h81000001);
  endtask

  task automatic t_req_ignored();
    logic [31:0] r, s;
    req_write(3'd0, 32'h12345678);
    @(negedge clk); req_addr = 3'd7; req_wdata = 32'h00000002; req_wr = 1;
    @(posedge clk); #1;
    check("R5 no notify", {31'b0, srv_notify}, 0);
    @(negedge clk); req_wr = 0;
    read_both(3'd0, r, s);
    check("R5 word0 kept", s, 32'hA5000000);
    read_both(3'd7, r, s);
    check("R5 header kept", s, 32'h81000001);
  endtask

  task automatic t_response(input logic [31:0] hdr, input logic [31:0] exp, string tag);
    logic [31:0] r, s;
    srv_write(3'd1, 32'hCAFE0000 | hdr);
    read_both(3'd1, r, s);
    check({tag, " srv data word"}, r, 32'hCAFE0000 | hdr);
    srv_write(3'd7, hdr | 32'h80000000);
    read_both(3'd7, r, s);
    check({tag, " response header"}, r, exp);
    check({tag, " owner returned"}, {31'b0, srv_owns}, 0);
  endtask

  task automatic t_fn_reset();
    logic [31:0] r, s;
    @(negedge clk); fn_in_reset = 1;
    for (int i = 0; i < 8; i++) begin
      read_both(3'(i), r, s);
      check("R8 all ones", r, 32'hFFFFFFFF);
    end
    read_both(3'd3, r, s);
    check("R8 srv port unaffected", s, 32'hA5003333);
    @(negedge clk); fn_in_reset = 0;
    read_both(3'd3, r, s);
    check("R8 contents back", r, 32'hA5003333);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_req_fill();
    t_srv_ignored();
    t_handoff();
    t_req_ignored();
    t_response(32'h00000081, 32'h00000081, "R7 success");
    req_write(3'd7, 32'h00000002);
    t_response(32'h00000582, 32'h00000582, "R7 failure status");
    t_fn_reset();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule